// File: doc/BRIEF.md
# Interleaved multiphase PWM generator

This block produces up to four interleaved pulse-width-modulated outputs for a multiphase buck regulator. Every phase runs its own up-counter over a programmable switching period, and the active phases start their ramps at evenly spaced points in that period. As a result, the combined ripple repeats once every period divided by the number of active phases. A single digital duty command sets the nominal pulse width. That width is capped at three quarters of the period and then corrected per phase by a current-balance term. The correction compares the phase's last sampled current with the average of all active phases.

The number of active phases is found once, just after reset, from two strap inputs. These inputs report whether the third and fourth outputs are tied off as unused. Each active phase raises a one-cycle sample strobe one third of a period after its pulse ends. On that strobe the block stores the phase's current input. The stored samples feed the average output, the balance arithmetic and an overcurrent flag.

A sequencer chooses, per output, between normal switching, a forced low level and a released (tri-stated) pin. A three-state controller orders start-up:
- ST_STRAP is the reset state, in which the straps and the period are captured.
- The strap_done transition leads to ST_ALIGN, in which the counters are loaded with their phase offsets.
- The align_done transition leads to ST_RUN, which the block holds until the next reset.

Top module: `mpwm_core`

## Requirements
- R1: One cycle after reset is released, the straps are captured and `phase_cnt` reports the result until the next reset. With `strap_hi[1]`=0 there are 4 phases. With `strap_hi[1:0]`=2'b10 there are 3 phases. With 2'b11 there are 2 phases. During reset, `phase_cnt` reads 4.
- R2: Only phases 0..n-1 are active. An inactive phase always has `pwm_oe`=0 and `pwm_out`=0, and never raises `sample_stb`.
- R3: The period P is taken from `period` in the strap cycle. Phase k's counter passes 0 exactly floor(k*P/n) cycles after phase 0's counter, so successive phases begin their pulses P/n cycles apart.
- R4: In ST_RUN, each active counter steps 0..P-1 and wraps. The output is high while the counter is below that phase's duty register. The duty register is cleared in ST_ALIGN and reloaded with the new duty each time the counter wraps to 0.
- R5: Let D = floor(3P/4). The duty command is first limited to D, and no reloaded duty ever exceeds D.
- R6: The reloaded duty is (limited command + (average − own sample) × GAIN), saturated to the range 0..D. A phase whose current is above the average therefore receives a narrower pulse.
- R7: `sample_stb[k]` is high for one cycle when the phase-k counter equals (duty register + floor(P/3)) mod P. At that clock edge, the phase's `isense` field is stored as its sample.
- R8: `avg_cur` equals floor(sum of the stored samples of the active phases / n). The samples are cleared to 0 by reset and by ST_ALIGN.
- R9: `ocp_flag` is high exactly when `avg_cur` exceeds floor(NOM_FULL × 165 / 100), which is 165 with the default parameters.
- R10: The 2-bit mode field `mode[2k+1:2k]` sets the output of an active phase in ST_RUN. Mode 00 selects normal switching with `pwm_oe`=1. Mode 01 drives `pwm_out`=0 with `pwm_oe`=1. Modes 10 and 11 release the pin, giving `pwm_oe`=0 and `pwm_out`=0.
- R11: During reset, and in ST_STRAP and ST_ALIGN, all of `pwm_oe`, `pwm_out` and `sample_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_hi | input | 2 | Strap inputs: bit 0 reports phase 2 unused, bit 1 reports phase 3 unused |
| period | input | CW | Switching period P in clocks, captured in ST_STRAP |
| duty_cmd | input | CW | Nominal duty in clocks |
| isense | input | 4*IW | Per-phase current values; phase k occupies bits [k*IW +: IW] |
| mode | input | 8 | Per-phase sequencer mode; phase k occupies bits [2k+1:2k] |
| pwm_out | output | 4 | PWM level per phase |
| pwm_oe | output | 4 | Output enable per phase (0 = released) |
| sample_stb | output | 4 | One-cycle current-sample strobe per phase |
| phase_cnt | output | 3 | Number of active phases (2, 3 or 4) |
| avg_cur | output | IW | Average of the stored samples of the active phases |
| ocp_flag | output | 1 | High when the average exceeds the overcurrent trip level |

## Verification
The assertions assume that `period` is at least 8 whenever it is captured. This keeps every strobe a single-cycle pulse and keeps the phase offsets distinct. They also assume that the straps are steady during the cycle after reset is released. The stimulus sets the straps and the period only while reset is held, and it changes `duty_cmd`, `isense` and `mode` one nanosecond after a rising edge. Periods between 20 and 40 are used, including an odd period with three phases, so that every division rounds.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    localparam int NPH = 4;

    typedef enum logic [1:0] {
        ST_STRAP = 2'd0,
        ST_ALIGN = 2'd1,
        ST_RUN   = 2'd2
    } mp_state_e;

    typedef enum logic [1:0] {
        MD_PWM = 2'd0,
        MD_LOW = 2'd1,
        MD_TRI = 2'd2,
        MD_OFF = 2'd3
    } mp_mode_e;

endpackage

// File: rtl/mpwm_detect.sv
// Captures the strap inputs once and derives the active-phase count and mask.
module mpwm_detect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic [1:0] strap,
    output logic [2:0] nph_q,
    output logic [3:0] act
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nph_q <= 3'd4;
        end else if (capture) begin
            if (strap[1]) nph_q <= strap[0] ? 3'd2 : 3'd3;
            else          nph_q <= 3'd4;
        end
    end

    always_comb begin
        unique case (nph_q)
            3'd2:    act = 4'b0011;
            3'd3:    act = 4'b0111;
            default: act = 4'b1111;
        endcase
    end

endmodule

// File: rtl/mpwm_balance.sv
// Averages the stored samples of the active phases and flags overcurrent.
module mpwm_balance #(
    parameter int NPH  = 4,
    parameter int IW   = 8,
    parameter int TRIP = 165
) (
    input  logic [2:0]        nph,
    input  logic [NPH-1:0]    act,
    input  logic [NPH*IW-1:0] samp,
    output logic [IW-1:0]     avg,
    output logic              ocp
);

    localparam int SUMW = IW + 2;

    logic [SUMW-1:0] sum;

    always_comb begin
        sum = '0;
        for (int i = 0; i < NPH; i++) begin
            if (act[i]) sum = sum + SUMW'(samp[i*IW +: IW]);
        end
    end

    always_comb begin
        unique case (nph)
            3'd2:    avg = IW'(sum >> 1);
            3'd3:    avg = IW'(sum / SUMW'(3));
            default: avg = IW'(sum >> 2);
        endcase
    end

    assign ocp = avg > IW'(TRIP);

endmodule

// File: rtl/mpwm_duty.sv
// Balanced duty for one phase: limited command plus weighted imbalance, saturated.
module mpwm_duty #(
    parameter int CW   = 10,
    parameter int IW   = 8,
    parameter int GAIN = 1
) (
    input  logic [CW-1:0] duty_cmd,
    input  logic [CW-1:0] dmax,
    input  logic [IW-1:0] avg,
    input  logic [IW-1:0] own,
    output logic [CW-1:0] dnext
);

    localparam int SW = CW + IW + 8;
    localparam logic signed [SW-1:0] GAIN_S = SW'(GAIN);

    logic [CW-1:0]        base;
    logic signed [SW-1:0] diff, base_s, dmax_s, total;

    assign base   = (duty_cmd > dmax) ? dmax : duty_cmd;
    assign diff   = $signed({{(SW-IW){1'b0}}, avg}) - $signed({{(SW-IW){1'b0}}, own});
    assign base_s = $signed({{(SW-CW){1'b0}}, base});
    assign dmax_s = $signed({{(SW-CW){1'b0}}, dmax});
    assign total  = base_s + diff * GAIN_S;

    always_comb begin
        if (total < 0)           dnext = '0;
        else if (total > dmax_s) dnext = dmax;
        else                     dnext = CW'(total);
    end

endmodule

// File: rtl/mpwm_channel.sv
// One phase: ramp counter, per-period duty register, sample strobe, output stage.
module mpwm_channel
    import mpwm_pkg::*;
#(
    parameter int CW   = 10,
    parameter int IW   = 8,
    parameter int GAIN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          align,
    input  logic          run,
    input  logic          act,
    input  logic [CW-1:0] per,
    input  logic [CW-1:0] init_cnt,
    input  logic [CW-1:0] third,
    input  logic [CW-1:0] dmax,
    input  logic [CW-1:0] duty_cmd,
    input  logic [IW-1:0] avg,
    input  logic [IW-1:0] cur_in,
    input  logic [1:0]    mode,
    output logic          pwm,
    output logic          oe,
    output logic          stb,
    output logic [IW-1:0] samp
);

    logic [CW-1:0] cnt_q, duty_q, dnext;
    logic          wrap;
    logic [CW:0]   sp, spw;

    mpwm_duty #(.CW(CW), .IW(IW), .GAIN(GAIN)) u_duty (
        .duty_cmd (duty_cmd),
        .dmax     (dmax),
        .avg      (avg),
        .own      (samp),
        .dnext    (dnext)
    );

    assign wrap = (cnt_q == per - 1'b1);
    assign sp   = {1'b0, duty_q} + {1'b0, third};
    assign spw  = (sp >= {1'b0, per}) ? (sp - {1'b0, per}) : sp;
    assign stb  = run && act && ({1'b0, cnt_q} == spw);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            duty_q <= '0;
            samp   <= '0;
        end else if (align) begin
            cnt_q  <= act ? init_cnt : '0;
            duty_q <= '0;
            samp   <= '0;
        end else if (run && act) begin
            if (stb) samp <= cur_in;
            if (wrap) begin
                cnt_q  <= '0;
                duty_q <= dnext;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        pwm = 1'b0;
        oe  = 1'b0;
        if (run && act) begin
            unique case (mp_mode_e'(mode))
                MD_PWM: begin
                    oe  = 1'b1;
                    pwm = (cnt_q < duty_q);
                end
                MD_LOW: oe = 1'b1;
                MD_TRI, MD_OFF: begin
                    oe  = 1'b0;
                    pwm = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mpwm_core.sv
// Top: start-up sequencer, period capture, phase offsets, per-phase channels.
module mpwm_core
    import mpwm_pkg::*;
#(
    parameter int CW       = 10,
    parameter int IW       = 8,
    parameter int GAIN     = 1,
    parameter int NOM_FULL = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_hi,
    input  logic [CW-1:0]     period,
    input  logic [CW-1:0]     duty_cmd,
    input  logic [NPH*IW-1:0] isense,
    input  logic [2*NPH-1:0]  mode,
    output logic [NPH-1:0]    pwm_out,
    output logic [NPH-1:0]    pwm_oe,
    output logic [NPH-1:0]    sample_stb,
    output logic [2:0]        phase_cnt,
    output logic [IW-1:0]     avg_cur,
    output logic              ocp_flag
);

    localparam int TRIP = NOM_FULL * 165 / 100;
    localparam int KW   = CW + 2;

    mp_state_e st_q, st_d;
    logic capture, align, run;
    logic [CW-1:0] per_q, third, dmax;
    logic [3:0]    act;
    logic [NPH*IW-1:0] samp_w;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STRAP;
        else        st_q <= st_d;
    end

    // transitions: strap_done, align_done
    always_comb begin
        unique case (st_q)
            ST_STRAP: st_d = ST_ALIGN;
            ST_ALIGN: st_d = ST_RUN;
            ST_RUN:   st_d = ST_RUN;
            default:  st_d = ST_STRAP;
        endcase
    end

    // state-decoded controls
    always_comb begin
        capture = (st_q == ST_STRAP);
        align   = (st_q == ST_ALIGN);
        run     = (st_q == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       per_q <= '0;
        else if (capture) per_q <= period;
    end

    assign third = per_q / CW'(3);
    assign dmax  = CW'(({2'b00, per_q} + {1'b0, per_q, 1'b0}) >> 2);

    mpwm_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .strap   (strap_hi),
        .nph_q   (phase_cnt),
        .act     (act)
    );

    mpwm_balance #(.NPH(NPH), .IW(IW), .TRIP(TRIP)) u_bal (
        .nph  (phase_cnt),
        .act  (act),
        .samp (samp_w),
        .avg  (avg_cur),
        .ocp  (ocp_flag)
    );

    for (genvar k = 0; k < NPH; k++) begin : g_ph
        logic [KW-1:0] kp;
        logic [CW-1:0] off, init;

        assign kp = KW'(k) * {2'b00, per_q};

        always_comb begin
            unique case (phase_cnt)
                3'd2:    off = CW'(kp >> 1);
                3'd3:    off = CW'(kp / KW'(3));
                default: off = CW'(kp >> 2);
            endcase
        end

        assign init = (off == '0) ? '0 : (per_q - off);

        mpwm_channel #(.CW(CW), .IW(IW), .GAIN(GAIN)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .align    (align),
            .run      (run),
            .act      (act[k]),
            .per      (per_q),
            .init_cnt (init),
            .third    (third),
            .dmax     (dmax),
            .duty_cmd (duty_cmd),
            .avg      (avg_cur),
            .cur_in   (isense[k*IW +: IW]),
            .mode     (mode[2*k +: 2]),
            .pwm      (pwm_out[k]),
            .oe       (pwm_oe[k]),
            .stb      (sample_stb[k]),
            .samp     (samp_w[k*IW +: IW])
        );
    end

endmodule

// File: rtl/mpwm_chk.sv
// Property checker attached to mpwm_core.
module mpwm_chk
    import mpwm_pkg::*;
#(
    parameter int CW = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run,
    input logic [CW-1:0]  per_q,
    input logic [2:0]     phase_cnt,
    input logic [NPH-1:0] pwm_out,
    input logic [NPH-1:0] pwm_oe,
    input logic [NPH-1:0] sample_stb
);

    logic [CW+1:0] lim;
    assign lim = ({2'b00, per_q} + {1'b0, per_q, 1'b0}) >> 2;

    for (genvar k = 0; k < NPH; k++) begin : g_k
        logic [CW+1:0] hi_len;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     hi_len <= '0;
            else if (pwm_out[k] && pwm_oe[k]) hi_len <= hi_len + 1'b1;
            else                            hi_len <= '0;
        end

        AST_DUTY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            (pwm_out[k] && pwm_oe[k]) |-> (hi_len < lim))
            else $error("pulse longer than three quarters of the period"); // R5

        AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            sample_stb[k] |=> !sample_stb[k])
            else $error("sample strobe longer than one cycle"); // R7
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_oe == '0 && pwm_out == '0 && sample_stb == '0))
        else $error("activity before run state"); // R11

    AST_TWO_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cnt == 3'd2) |-> (pwm_oe[3:2] == 2'b00 && sample_stb[3:2] == 2'b00))
        else $error("unused phase active with two phases"); // R2

    AST_THREE_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cnt == 3'd3) |-> (!pwm_oe[3] && !sample_stb[3]))
        else $error("unused phase active with three phases"); // R2

    AST_PCNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> $stable(phase_cnt))
        else $error("phase count changed while running"); // R1

    AST_PCNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cnt == 3'd2 || phase_cnt == 3'd3 || phase_cnt == 3'd4))
        else $error("illegal phase count"); // R1

endmodule

bind mpwm_core mpwm_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .per_q      (per_q),
    .phase_cnt  (phase_cnt),
    .pwm_out    (pwm_out),
    .pwm_oe     (pwm_oe),
    .sample_stb (sample_stb)
);

// File: tb/mpwm_core_tb.sv
`timescale 1ns/1ps
module mpwm_core_tb;

    localparam int CW   = 10;
    localparam int IW   = 8;
    localparam int GAIN = 1;
    localparam int TRIP = 165;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n    = 1'b0;
    logic [1:0]    strap_hi = 2'b00;
    logic [CW-1:0] period   = 10'd40;
    logic [CW-1:0] duty_cmd = '0;
    logic [4*IW-1:0] isense = '0;
    logic [7:0]    mode     = '0;
    logic [3:0]    pwm_out, pwm_oe, sample_stb;
    logic [2:0]    phase_cnt;
    logic [IW-1:0] avg_cur;
    logic          ocp_flag;

    mpwm_core u_dut (
        .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .period(period),
        .duty_cmd(duty_cmd), .isense(isense), .mode(mode),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe), .sample_stb(sample_stb),
        .phase_cnt(phase_cnt), .avg_cur(avg_cur), .ocp_flag(ocp_flag)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mst = 0, mn = 4, mP = 0;
    int mcnt[4], mduty[4], msamp[4];

    function automatic bit m_act(input int k);
        return k < mn;
    endfunction

    function automatic int m_avg();
        int s = 0;
        for (int k = 0; k < 4; k++) if (m_act(k)) s += msamp[k];
        return s / mn;
    endfunction

    function automatic int m_dnext(input int k);
        int dm, base, s;
        dm   = (3 * mP) / 4;
        base = (int'(duty_cmd) > dm) ? dm : int'(duty_cmd);
        s    = base + (m_avg() - msamp[k]) * GAIN;
        if (s < 0)  s = 0;
        if (s > dm) s = dm;
        return s;
    endfunction

    function automatic int m_sp(input int k);
        int s = mduty[k] + mP / 3;
        if (s >= mP) s -= mP;
        return s;
    endfunction

    always @(posedge clk) cyc++;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst = 0; mn = 4; mP = 0;
            for (int k = 0; k < 4; k++) begin mcnt[k] = 0; mduty[k] = 0; msamp[k] = 0; end
        end else begin
            case (mst)
                0: begin
                    if (strap_hi[1]) mn = strap_hi[0] ? 2 : 3;
                    else             mn = 4;
                    mP  = int'(period);
                    mst = 1;
                end
                1: begin
                    for (int k = 0; k < 4; k++) begin
                        mcnt[k]  = (m_act(k) && k != 0) ? mP - (k * mP) / mn : 0;
                        mduty[k] = 0;
                        msamp[k] = 0;
                    end
                    mst = 2;
                end
                default: begin
                    bit sb[4];
                    bit wr[4];
                    int nd[4];
                    for (int k = 0; k < 4; k++) begin
                        sb[k] = m_act(k) && (mcnt[k] == m_sp(k));
                        wr[k] = (mcnt[k] == mP - 1);
                        nd[k] = m_dnext(k);
                    end
                    for (int k = 0; k < 4; k++) begin
                        if (m_act(k)) begin
                            if (sb[k]) msamp[k] = int'(isense[k*IW +: IW]);
                            if (wr[k]) begin mcnt[k] = 0; mduty[k] = nd[k]; end
                            else mcnt[k] = mcnt[k] + 1;
                        end
                    end
                end
            endcase
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int k = 0; k < 4; k++) begin
                bit eo, ep, es;
                eo = 0; ep = 0;
                if (mst == 2 && m_act(k)) begin
                    case (mode[2*k +: 2])
                        2'd0: begin eo = 1; ep = (mcnt[k] < mduty[k]); end
                        2'd1: eo = 1;
                        default: eo = 0;
                    endcase
                end
                es = (mst == 2) && m_act(k) && (mcnt[k] == m_sp(k));
                chk(pwm_out[k] == ep, $sformatf("R4 pwm_out[%0d]", k), int'(pwm_out[k]), int'(ep));
                chk(pwm_oe[k] == eo, $sformatf("R10 pwm_oe[%0d]", k), int'(pwm_oe[k]), int'(eo));
                chk(sample_stb[k] == es, $sformatf("R7 sample_stb[%0d]", k), int'(sample_stb[k]), int'(es));
            end
            chk(int'(phase_cnt) == mn, "R1 phase_cnt", int'(phase_cnt), mn);
            chk(int'(avg_cur) == m_avg(), "R8 avg_cur", int'(avg_cur), m_avg());
            chk(ocp_flag == (m_avg() > TRIP), "R9 ocp_flag", int'(ocp_flag), int'(m_avg() > TRIP));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic setup(input logic [1:0] st, input int p);
        @(posedge clk); #1;
        rst_n    = 1'b0;
        strap_hi = st;
        period   = CW'(p);
        mode     = '0;
        @(negedge clk);
        chk(pwm_oe == 4'h0 && pwm_out == 4'h0, "R11 outputs in reset", int'(pwm_oe), 0);
        chk(sample_stb == 4'h0, "R11 strobe in reset", int'(sample_stb), 0);
        chk(phase_cnt == 3'd4, "R1 reset phase count", int'(phase_cnt), 4);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_oe == 4'h0, "R11 outputs in strap state", int'(pwm_oe), 0);
    endtask

    task automatic set_cur(input int c0, input int c1, input int c2, input int c3);
        @(posedge clk); #1;
        isense = {IW'(c3), IW'(c2), IW'(c1), IW'(c0)};
    endtask

    task automatic wait_rise(input int k, output int t);
        bit prev;
        @(negedge clk);
        prev = pwm_out[k];
        t = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (pwm_out[k] && !prev) begin t = cyc; break; end
            prev = pwm_out[k];
        end
    endtask

    task automatic wait_stb(input int k, output int t);
        t = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (sample_stb[k]) begin t = cyc; break; end
        end
    endtask

    task automatic measure_high(input int k, output int w);
        int t;
        wait_rise(k, t);
        w = (t < 0) ? 0 : 1;
        for (int i = 0; i < 2000 && t >= 0; i++) begin
            @(negedge clk);
            if (pwm_out[k]) w++;
            else break;
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    // ---------------- directed scenarios ----------------
    initial begin
        int t0, t1, t2, w, seen;

        // four phases, balanced currents
        setup(2'b00, 40);
        duty_cmd = 10'd12;
        set_cur(50, 50, 50, 50);
        wait_cycles(150);
        chk(phase_cnt == 3'd4, "R1 four phases", int'(phase_cnt), 4);
        wait_rise(0, t0); wait_rise(1, t1); wait_rise(2, t2);
        chk(t1 - t0 == 10, "R3 phase1 offset (4 ph)", t1 - t0, 10);
        chk(t2 - t0 == 20, "R3 phase2 offset (4 ph)", t2 - t0, 20);
        measure_high(0, w);
        chk(w == 12, "R4 pulse width", w, 12);
        chk(avg_cur == 8'd50, "R8 average", int'(avg_cur), 50);
        chk(!ocp_flag, "R9 no overcurrent", int'(ocp_flag), 0);

        // four phases, unequal currents: both saturation ends
        setup(2'b00, 40);
        duty_cmd = 10'd12;
        set_cur(80, 40, 60, 20);
        wait_cycles(200);
        measure_high(1, w);
        chk(w == 22, "R6 below-average phase widened", w, 22);
        measure_high(2, w);
        chk(w == 2, "R6 above-average phase narrowed", w, 2);
        measure_high(3, w);
        chk(w == 30, "R5 saturated at three quarters", w, 30);
        seen = 0;
        repeat (80) begin @(negedge clk); if (pwm_out[0]) seen++; end
        chk(seen == 0, "R6 saturated at zero", seen, 0);
        chk(avg_cur == 8'd50, "R8 unequal average", int'(avg_cur), 50);

        // three phases, oversized command, overcurrent, unused current ignored
        setup(2'b10, 30);
        duty_cmd = 10'd1000;
        set_cur(200, 190, 210, 255);
        wait_cycles(150);
        chk(phase_cnt == 3'd3, "R1 three phases", int'(phase_cnt), 3);
        chk(avg_cur == 8'd200, "R8 three-phase average", int'(avg_cur), 200);
        chk(ocp_flag, "R9 overcurrent", int'(ocp_flag), 1);
        measure_high(0, w);
        chk(w == 22, "R5 command limited", w, 22);
        measure_high(2, w);
        chk(w == 12, "R6 three-phase trim", w, 12);
        wait_rise(0, t0); wait_rise(1, t1);
        chk(t1 - t0 == 10, "R3 phase1 offset (3 ph)", t1 - t0, 10);
        chk(pwm_oe[3] == 1'b0, "R2 fourth output released", int'(pwm_oe[3]), 0);

        // two phases and sequencer modes
        setup(2'b11, 20);
        duty_cmd = 10'd6;
        set_cur(40, 40, 255, 255);
        wait_cycles(100);
        chk(phase_cnt == 3'd2, "R1 two phases", int'(phase_cnt), 2);
        seen = 0;
        repeat (40) begin @(negedge clk); if (pwm_oe[3:2] != 2'b00 || sample_stb[3:2] != 2'b00) seen++; end
        chk(seen == 0, "R2 unused phases quiet", seen, 0);
        wait_rise(0, t0); wait_rise(1, t1);
        chk(t1 - t0 == 10, "R3 phase1 offset (2 ph)", t1 - t0, 10);
        @(posedge clk); #1 mode[3:2] = 2'b01;
        seen = 0;
        repeat (40) begin @(negedge clk); if (!pwm_oe[1] || pwm_out[1]) seen++; end
        chk(seen == 0, "R10 forced low", seen, 0);
        @(posedge clk); #1 mode = 8'b0000_1110;
        seen = 0;
        repeat (40) begin @(negedge clk); if (pwm_oe[1:0] != 2'b00 || pwm_out[1:0] != 2'b00) seen++; end
        chk(seen == 0, "R10 released modes", seen, 0);

        // three phases, odd period
        setup(2'b10, 37);
        duty_cmd = 10'd9;
        set_cur(30, 30, 30, 0);
        wait_cycles(150);
        wait_rise(0, t0); wait_rise(1, t1); wait_rise(2, t2);
        chk(t1 - t0 == 12, "R3 odd period phase1", t1 - t0, 12);
        chk(t2 - t0 == 24, "R3 odd period phase2", t2 - t0, 24);
        wait_stb(0, t1); wait_stb(0, t2);
        chk(t2 - t1 == 37, "R7 strobe once per period", t2 - t1, 37);
        set_cur(60, 30, 30, 0);
        wait_cycles(120);
        chk(avg_cur == 8'd40, "R8 new sample taken", int'(avg_cur), 40);
        measure_high(1, w);
        chk(w == 19, "R6 trim after new sample", w, 19);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule